// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the internal word address for a four-beat burst into a synchronous memory. A controller supplies two pulses. The first is a load pulse, issued when an address strobe is accepted. The second is an active-low advance, issued on every clock on which the burst should move to its next beat.

On a load, the block captures the whole presented address. The field above the two beat-select bits passes through unchanged for the whole burst. The two beat-select bits step through four values in the order chosen by a static mode input:
- **Interleaved:** each beat is the start value XOR the beat count.
- **Linear:** the start value counts up modulo four.

After the fourth beat the sequence returns to its starting value. A flag marks the fourth beat.

Top module: `burst_addr_seq`

## Requirements
- R1: With `order_sel` = 1 (interleaved), beat k (k = 0..3 after a load) drives `addr_out[1:0]` = start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R2: With `order_sel` = 0 (linear), beat k drives `addr_out[1:0]` = (start + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R3: On a clock edge where `load` = 0 and `adv_n` = 1, `addr_out` and `last_beat` keep their values.
- R4: An advance taken from the fourth beat returns `addr_out[1:0]` to the starting value and the beat count to 0.
- R5: `load` = 1 at any point restarts the sequence at beat 0 from the newly presented `addr_in`. This holds even mid-burst, and `load` takes priority over `adv_n` on the same edge.
- R6: `addr_out[ADDR_W-1:2]` equals `addr_in[ADDR_W-1:2]` as captured at the last load. Advancing never changes it, including when the low bits wrap from 11 to 00.
- R7: `last_beat` = 1 exactly while the beat count is 3, and it is 0 on beat 0 after a load.
- R8: While reset is asserted, and after it is released until the first load, `addr_out` = 0 and `last_beat` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| order_sel | input | 1 | Static burst order: 1 interleaved, 0 linear |
| load | input | 1 | Capture `addr_in` and restart at beat 0 |
| addr_in | input | ADDR_W | Presented starting address |
| adv_n | input | 1 | Active-low advance to the next beat |
| addr_out | output | ADDR_W | Internal word address of the current beat |
| last_beat | output | 1 | High on the fourth beat |

## Verification
Full bursts are run from every start value in both orders. Together these tell the XOR sequence apart from the increment sequence, and they expose a wrap that lands anywhere other than the start. Advances are interleaved with idle clocks to show that a suspended beat holds its address and flag. Loads are issued mid-burst and together with an advance, to check that a restart wins and begins at beat 0. A linear burst from start 11 under an all-ones upper field shows that no carry leaks into the passed-through bits.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } burst_order_e;
endpackage

// File: rtl/reset_release_sync.sv
module reset_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= 1'b1;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 step,
  output logic [BEAT_BITS-1:0] beat,
  output logic                 final_beat
);
  localparam logic [BEAT_BITS-1:0] BEAT_MAX = {BEAT_BITS{1'b1}};

  logic [BEAT_BITS-1:0] beat_q, beat_d;
  logic                 beat_en;

  always_comb begin
    beat_en = restart | step;
    beat_d  = beat_q;
    if (restart)   beat_d = '0;
    else if (step) beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat       = beat_q;
  assign final_beat = (beat_q == BEAT_MAX);

  // R4: a step from the final beat wraps the count to zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && step && beat_q == BEAT_MAX) |=> (beat == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_BITS = 2
) (
  input  burst_seq_pkg::burst_order_e order,
  input  logic [BEAT_BITS-1:0]        start,
  input  logic [BEAT_BITS-1:0]        beat,
  output logic [BEAT_BITS-1:0]        sel
);
  import burst_seq_pkg::*;

  logic [BEAT_BITS-1:0] lin_sel, ilv_sel;

  always_comb begin
    lin_sel = start + beat;
    ilv_sel = start ^ beat;
    sel     = (order == ORDER_INTERLEAVED) ? ilv_sel : lin_sel;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W      = 15,
  parameter int BEAT_BITS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_sel,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              adv_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  import burst_seq_pkg::*;

  localparam int UPPER_W = ADDR_W - BEAT_BITS;

  logic                 rst_sync_n;
  logic [BEAT_BITS-1:0] start_q, start_d;
  logic [UPPER_W-1:0]   upper_q, upper_d;
  logic [BEAT_BITS-1:0] beat;
  logic [BEAT_BITS-1:0] low_sel;
  logic                 step;
  burst_order_e         order;

  reset_release_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign step  = ~adv_n;
  assign order = burst_order_e'(order_sel);

  always_comb begin
    start_d = addr_in[BEAT_BITS-1:0];
    upper_d = addr_in[ADDR_W-1:BEAT_BITS];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      start_q <= '0;
      upper_q <= '0;
    end else if (load) begin
      start_q <= start_d;
      upper_q <= upper_d;
    end
  end

  burst_beat_ctr #(.BEAT_BITS(BEAT_BITS)) i_beat_ctr (
    .clk(clk), .rst_n(rst_sync_n), .restart(load), .step(step),
    .beat(beat), .final_beat(last_beat)
  );

  burst_order_map #(.BEAT_BITS(BEAT_BITS)) i_order_map (
    .order(order), .start(start_q), .beat(beat), .sel(low_sel)
  );

  assign addr_out = {upper_q, low_sel};

  // R3: no load and no advance leaves the address and flag unchanged
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && adv_n) |=> ($stable(addr_out) && $stable(last_beat)));

  // R5: a load shows the presented address on the next beat
  a_r5_load_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> (addr_out == $past(addr_in)));

  // R7: beat 0 after a load is never the final beat
  a_r7_first_not_last: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> !last_beat);

  // R6: an advance leaves the upper field untouched
  a_r6_upper_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && !adv_n) |=> $stable(addr_out[ADDR_W-1:BEAT_BITS]));

  // R2: in linear order each advance adds one to the low bits
  a_r2_linear_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!order_sel && !load && !adv_n) |=>
      (addr_out[BEAT_BITS-1:0] == $past(addr_out[BEAT_BITS-1:0]) + 1'b1));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int  ADDR_W = 15;
  localparam time PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              order_sel = 1'b0;
  logic              load = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              adv_n = 1'b1;
  logic [ADDR_W-1:0] addr_out;
  logic              last_beat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .load(load),
    .addr_in(addr_in), .adv_n(adv_n), .addr_out(addr_out), .last_beat(last_beat)
  );

  function automatic logic [1:0] exp_low(input logic ilv, input logic [1:0] st,
                                         input logic [1:0] k);
    return ilv ? (st ^ k) : (st + k);
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp_a,
                       input logic exp_l);
    checks++;
    if (addr_out !== exp_a || last_beat !== exp_l) begin
      errors++;
      $display("FAIL %s: addr_out=%h last=%b expected addr_out=%h last=%b",
               req, addr_out, last_beat, exp_a, exp_l);
    end
  endtask

  // Drive at a falling edge; results are sampled at the following falling edge.
  task automatic do_load(input logic [ADDR_W-1:0] a, input logic adv_too);
    load = 1'b1; addr_in = a; adv_n = ~adv_too;
    @(negedge clk);
    load = 1'b0; adv_n = 1'b1;
  endtask

  task automatic advance();
    adv_n = 1'b0;
    @(negedge clk);
    adv_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R8 during reset", '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 after release", '0, 1'b0);
  endtask

  task automatic t_full_burst(input logic ilv, input logic [1:0] st,
                              input logic [ADDR_W-3:0] up);
    string req;
    req = ilv ? "R1" : "R2";
    order_sel = ilv;
    do_load({up, st}, 1'b0);
    check({req, " beat0 / R7"}, {up, st}, 1'b0);
    for (int k = 1; k < 4; k++) begin
      advance();
      check({req, " beat / R6 / R7"}, {up, exp_low(ilv, st, 2'(k))}, k == 3);
    end
    advance();
    check("R4 wrap to start", {up, st}, 1'b0);
  endtask

  task automatic t_hold();
    order_sel = 1'b0;
    do_load(15'h1230, 1'b0);
    advance();
    repeat (3) @(negedge clk);
    check("R3 hold mid burst", 15'h1231, 1'b0);
    advance(); advance();
    repeat (2) @(negedge clk);
    check("R3 hold on last beat", 15'h1233, 1'b1);
  endtask

  task automatic t_restart();
    order_sel = 1'b1;
    do_load(15'h0A01, 1'b0);
    advance();
    check("R1 interleaved step", 15'h0A00, 1'b0);
    do_load(15'h5556, 1'b0);
    check("R5 restart mid burst", 15'h5556, 1'b0);
    advance(); advance();
    do_load(15'h2223, 1'b1);
    check("R5 load beats advance", 15'h2223, 1'b0);
    advance();
    check("R5 beat1 after restart", 15'h2222, 1'b0);
  endtask

  task automatic t_no_carry();
    order_sel = 1'b0;
    do_load(15'h7FFF, 1'b0);
    advance();
    check("R6 no carry into upper", 15'h7FFC, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    for (int s = 0; s < 4; s++) begin
      t_full_burst(1'b1, 2'(s), 13'h0155 + 13'(s));
      t_full_burst(1'b0, 2'(s), 13'h1AAA - 13'(s));
    end
    t_hold();
    t_restart();
    t_no_carry();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule